// File: doc/BRIEF.md
# Low-Precision Barker Correlator

This block despreads a stream of filtered complex baseband samples against the 11-chip Barker code and emits one energy-like correlation magnitude for every sample it accepts. It keeps only the two most significant bits of each I and Q sample. These bits are treated as a signed value in the range -2..1 and stored in one delay line per channel. The delay line is tapped once per chip, with a tap spacing of `SPC` samples. Each tap is added or subtracted according to its code chip, and the terms are summed by a binary adder tree. The two channel sums are squared, and the squares are added into a saturating magnitude.

A downstream peak detector places its threshold and periodicity decisions on the magnitude stream. Both stream edges use valid/ready. Data moves on a clock edge where valid and ready are both high. The whole pipeline advances together. `s_ready` is high whenever the output register is empty or the consumer is taking its value. While `m_valid` is high and `m_ready` is low, the block holds its output and takes no new sample. The producer may drop `s_valid` at any time, and the consumer may drop `m_ready` at any time.

Top module: `lp_barker_corr`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1. Both delay lines hold zeros, so the earliest outputs are computed as if all samples before the first accepted one were 0.
- R2: Only bits [IN_W-1:IN_W-2] of `s_i` and `s_q` affect the result. Those bits are read as a two's-complement value (01=+1, 00=0, 11=-1, 10=-2). The lower bits have no effect on `m_mag`.
- R3: Let x[n] be the newest accepted value and take the code c0..c10 = +1 -1 +1 +1 -1 +1 +1 +1 -1 -1 -1. The channel sum after sample n is S = sum over j of c_j·x[n-(10-j)·SPC]. The newest sample is therefore weighted by c10.
- R4: The magnitude is S_I² + S_Q², where each sum is computed as in R3 on its own channel.
- R5: Exactly one `m_mag` value is produced per accepted sample, in acceptance order. While `m_ready` stays high, the value appears 4 cycles after the acceptance edge.
- R6: `s_ready` = !m_valid || m_ready. While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_mag` is held unchanged into the next cycle.
- R7: The delay lines shift only on accepted samples. Cycles without a transfer do not change any later result.
- R8: The sum of squares saturates at 2^MAG_W-1. The largest reachable value, 578 (17² on both channels), is produced exactly and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_i | input | IN_W | In-phase filter output |
| s_q | input | IN_W | Quadrature filter output |
| m_valid | output | 1 | Magnitude valid |
| m_ready | input | 1 | Consumer accepts magnitude |
| m_mag | output | MAG_W | Correlation magnitude S_I²+S_Q² |

## Verification
A lone sample after reset shows the zero-filled history and the pipeline latency.

An exact ±1 Barker burst on I checks the chip order and the tap spacing: a reversed or mis-spaced code would give no peak of 121. A burst with the negated code on Q then shows that the two channels are squared independently and added.

A worst-case burst with -2 on the positive chips and +1 on the negative chips checks the widest sum, 578, against wrap-around.

A long pseudo-random run with random low bits, gaps in `s_valid` and stalls on `m_ready` covers all 16 top-bit pairs. It separates use of the top bits only, shifting only on transfer, and the hold rule under back-pressure.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int unsigned BC_CHIPS = 11;
  // bit j set means chip j is +1; chip 0 is the first chip sent
  localparam logic [BC_CHIPS-1:0] BC_CODE = 11'b00011101101;
endpackage

// File: rtl/lbc_tap_line.sv
module lbc_tap_line
  import lbc_pkg::*;
#(
  parameter int SPC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift,
  input  logic [1:0]              din,
  output logic [BC_CHIPS*2-1:0]   taps
);
  localparam int SPAN = (BC_CHIPS - 1) * SPC + 1;

  logic [SPAN-1:0][1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (shift) begin
      line_q[0] <= din;
      for (int k = 1; k < SPAN; k++) line_q[k] <= line_q[k-1];
    end
  end

  // chip j sees the sample (BC_CHIPS-1-j)*SPC positions back
  for (genvar j = 0; j < BC_CHIPS; j++) begin : g_tap
    assign taps[2*j +: 2] = line_q[(BC_CHIPS-1-j)*SPC];
  end

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(line_q)); // R7
endmodule

// File: rtl/lbc_tree.sv
module lbc_tree
  import lbc_pkg::*;
#(
  parameter int SUM_W = 6
) (
  input  logic [BC_CHIPS*2-1:0]   taps,
  output logic signed [SUM_W-1:0] sum
);
  localparam int LV = $clog2(BC_CHIPS);
  localparam int NP = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int W = NP >> l;
    logic signed [SUM_W-1:0] nd [W];
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_k
        if (k < BC_CHIPS) begin : g_term
          logic signed [SUM_W-1:0] ext;
          assign ext = {{(SUM_W-2){taps[2*k+1]}}, taps[2*k +: 2]};
          assign nd[k] = BC_CODE[k] ? ext : -ext;
        end else begin : g_pad
          assign nd[k] = '0;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        assign nd[k] = g_lv[l-1].nd[2*k] + g_lv[l-1].nd[2*k+1];
      end
    end
  end

  assign sum = g_lv[LV].nd[0];
endmodule

// File: rtl/lbc_energy.sv
module lbc_energy #(
  parameter int SUM_W = 6,
  parameter int MAG_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic signed [SUM_W-1:0] sum_a,
  input  logic signed [SUM_W-1:0] sum_b,
  output logic [MAG_W-1:0]        mag
);
  localparam int SQ_W  = 2 * SUM_W;
  localparam int RAW_W = (SQ_W + 1 > MAG_W) ? SQ_W + 1 : MAG_W;
  localparam logic [RAW_W-1:0] MAXV = RAW_W'((64'd1 << MAG_W) - 64'd1);

  logic [SUM_W-1:0] abs_a, abs_b;
  logic [SQ_W-1:0]  sq_a_q, sq_b_q;
  logic [RAW_W-1:0] raw;
  logic [MAG_W-1:0] mag_q;

  assign abs_a = sum_a[SUM_W-1] ? SUM_W'(-sum_a) : SUM_W'(sum_a);
  assign abs_b = sum_b[SUM_W-1] ? SUM_W'(-sum_b) : SUM_W'(sum_b);
  assign raw   = RAW_W'(sq_a_q) + RAW_W'(sq_b_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_a_q <= '0;
      sq_b_q <= '0;
      mag_q  <= '0;
    end else if (adv) begin
      sq_a_q <= SQ_W'(abs_a) * SQ_W'(abs_a);
      sq_b_q <= SQ_W'(abs_b) * SQ_W'(abs_b);
      mag_q  <= (raw > MAXV) ? MAXV[MAG_W-1:0] : raw[MAG_W-1:0];
    end
  end

  assign mag = mag_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (RAW_W'(mag_q) >= RAW_W'($past(sq_a_q)))); // R8
endmodule

// File: rtl/lp_barker_corr.sv
module lp_barker_corr
  import lbc_pkg::*;
#(
  parameter int SPC   = 2,
  parameter int IN_W  = 12,
  parameter int MAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [IN_W-1:0]  s_i,
  input  logic [IN_W-1:0]  s_q,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [MAG_W-1:0] m_mag
);
  localparam int SUM_W  = $clog2(2 * BC_CHIPS + 1) + 1;
  localparam int STAGES = 4;

  logic                    adv, take;
  logic [STAGES-1:0]       vld_q;
  logic [1:0]              msb [2];
  logic [BC_CHIPS*2-1:0]   taps [2];
  logic signed [SUM_W-1:0] tree_sum [2];
  logic signed [SUM_W-1:0] sum_q [2];
  logic                    lsb_unused;

  assign adv     = !vld_q[STAGES-1] || m_ready;
  assign s_ready = adv;
  assign take    = s_valid && adv;
  assign m_valid = vld_q[STAGES-1];

  assign msb[0]     = s_i[IN_W-1 -: 2];
  assign msb[1]     = s_q[IN_W-1 -: 2];
  assign lsb_unused = ^{s_i[IN_W-3:0], s_q[IN_W-3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (adv) vld_q <= {vld_q[STAGES-2:0], s_valid};
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    lbc_tap_line #(.SPC(SPC)) u_line (
      .clk(clk), .rst_n(rst_n), .shift(take), .din(msb[c]), .taps(taps[c])
    );
    lbc_tree #(.SUM_W(SUM_W)) u_tree (
      .taps(taps[c]), .sum(tree_sum[c])
    );
    always_ff @(posedge clk) begin
      if (!rst_n) sum_q[c] <= '0;
      else if (adv) sum_q[c] <= tree_sum[c];
    end
  end

  lbc_energy #(.SUM_W(SUM_W), .MAG_W(MAG_W)) u_energy (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .sum_a(sum_q[0]), .sum_b(sum_q[1]), .mag(m_mag)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_mag))); // R6
  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q[1] |-> (int'(sum_q[0]) <= 2*int'(BC_CHIPS) && int'(sum_q[0]) >= -2*int'(BC_CHIPS)
               && int'(sum_q[1]) <= 2*int'(BC_CHIPS) && int'(sum_q[1]) >= -2*int'(BC_CHIPS))); // R3
endmodule

// File: tb/sim_lp_barker_corr.sv
module sim_lp_barker_corr;
  localparam int CLK_P = 10;
  localparam int SPC   = 2;
  localparam int IN_W  = 12;
  localparam int NC    = 11;
  localparam int SPAN  = (NC - 1) * SPC + 1;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, m_valid, m_ready = 0;
  logic [IN_W-1:0] s_i = '0, s_q = '0;
  logic [11:0] m_mag;

  lp_barker_corr #(.SPC(SPC), .IN_W(IN_W), .MAG_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .m_valid(m_valid), .m_ready(m_ready), .m_mag(m_mag)
  );

  always #(CLK_P/2) clk = ~clk;

  int chip [NC] = '{1, -1, 1, 1, -1, 1, 1, 1, -1, -1, -1};
  int hi [SPAN];
  int hq [SPAN];
  int expq [64];
  int pcyc [64];
  int head = 0, tail = 0, cyc = 0;
  int n_run = 0, n_fail = 0, max_seen = 0;
  bit lat_chk = 0, stall_seen = 0;
  int stall_val = 0;
  string tag = "R1";

  function automatic int top2(logic [IN_W-1:0] v);
    return int'($signed(v[IN_W-1 -: 2]));
  endfunction

  function automatic logic [IN_W-1:0] enc(int v, logic [IN_W-3:0] low);
    logic [1:0] t;
    t = 2'(v);
    return {t, low};
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycle(bit sv, logic [IN_W-1:0] di, logic [IN_W-1:0] dq, bit mr);
    int si, sq, e;
    @(negedge clk);
    s_valid = sv; s_i = di; s_q = dq; m_ready = mr;
    #(CLK_P/4);
    cyc++;
    if (stall_seen) check("R6", m_valid ? int'(m_mag) : -1, stall_val);
    stall_seen = m_valid && !m_ready;
    stall_val  = int'(m_mag);
    if (m_valid && !m_ready) check("R6", int'(s_ready), 0);
    if (m_valid && m_ready) begin
      if (head == tail) check(tag, int'(m_mag), -1);
      else begin
        check(tag, int'(m_mag), expq[head]);
        if (lat_chk) check("R5", cyc - pcyc[head], 4);
        if (int'(m_mag) > max_seen) max_seen = int'(m_mag);
        head = (head + 1) % 64;
      end
    end
    if (sv && s_ready) begin
      for (int k = SPAN - 1; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
      hi[0] = top2(di); hq[0] = top2(dq);
      si = 0; sq = 0;
      for (int j = 0; j < NC; j++) begin
        si += chip[j] * hi[(NC-1-j)*SPC];
        sq += chip[j] * hq[(NC-1-j)*SPC];
      end
      e = si*si + sq*sq;
      if (e > 4095) e = 4095;
      expq[tail] = e; pcyc[tail] = cyc;
      tail = (tail + 1) % 64;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) cycle(0, '0, '0, 1);
  endtask

  task automatic burst(int sel, bit gaps);
    // sel 0: code on I; 1: code on I, negated on Q; 2: worst case both
    int vi, vq;
    for (int j = 0; j < NC; j++)
      for (int r = 0; r < SPC; r++) begin
        if (sel == 2) begin vi = chip[j] > 0 ? -2 : 1; vq = vi; end
        else begin vi = chip[j]; vq = (sel == 1) ? -chip[j] : 0; end
        if (gaps) cycle(0, '1, '1, 1);
        cycle(1, enc(vi, '0), enc(vq, '0), 1);
      end
    for (int k = 0; k < 2*SPAN; k++) cycle(1, '0, '0, 1);
    drain();
  endtask

  initial begin
    for (int k = 0; k < SPAN; k++) begin hi[k] = 0; hq[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #(CLK_P/4);
    check("R1", int'(m_valid), 0);
    check("R1", int'(s_ready), 1);

    // R1/R5: lone sample after reset, zero history, latency
    lat_chk = 1; tag = "R1";
    cycle(1, enc(1, '0), '0, 1);
    drain();

    tag = "R3"; burst(0, 0);
    tag = "R4"; burst(1, 0);
    tag = "R8"; max_seen = 0; burst(2, 0);
    check("R8", max_seen, 578);
    tag = "R7"; lat_chk = 0; burst(1, 1);

    // R2/R6/R7: random top bits, random low bits, gaps and stalls
    tag = "R2";
    for (int k = 0; k < 3000; k++)
      cycle(($urandom % 4) != 0, IN_W'($urandom), IN_W'($urandom), ($urandom % 10) < 7);
    drain();
    check("R5", (tail - head + 64) % 64, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule